// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits between instruction decode and issue in an in-order core that has two execution pipes. In each cycle it receives two decoded instruction descriptors in program order. The older instruction is the candidate for the primary pipe (slot U). The younger instruction is the candidate for the secondary pipe (slot V). The block decides whether the two may issue together. If they may not, only the older instruction issues, and the block gives a numeric reason for the refusal.

The decision is a fixed set of rules. Some operation classes are confined to one slot. Neither instruction may carry both a displacement and an immediate. Prefix bytes are allowed only in slot U, except that a conditional branch whose only extra byte is the two-byte escape may still go in slot V. The slot-U instruction must be one byte long, or its predecode-valid bit must be set. Register and flag dependencies between the two instructions also block pairing, with one exemption: a compare or test followed by a conditional branch may pair. The decision is combinational, and one register stage follows it. The decoder builds the register masks without the implicit stack-pointer updates of push, pop and call, so stack operations can pair back to back. An explicit stack-pointer operand still appears in the masks.

Top module: `pair_check`

## Requirements
- R1: If either `u_valid` or `v_valid` is low, `pair_ok` is low and `reason` is 1.
- R2: Class codes are: 0 move, 1 ALU (add/and/or/xor/sub), 2 add/sub with carry, 3 compare/test, 4 inc/dec, 5 push/pop register, 6 load-effective-address, 7 no-op, 8 shift/rotate by 1 or by an immediate, 9 rotate-through-carry by an immediate, 10 near jump, 11 near call, 12 conditional branch, 13 to 15 complex. A pair is refused with reason 2 if either simple flag is low, or if either class is 9 or 13 or higher.
- R3: Class 8 in slot V gives reason 3.
- R4: Class 2 in slot U gives reason 4.
- R5: A class from 10 to 12 in slot U gives reason 5.
- R6: An instruction in either slot with both `*_disp` and `*_imm` high gives reason 6.
- R7: In slot V, reason 7 is given if `v_pfx` is high, or if `v_esc` is high and the class is not 12. Prefixes in slot U are accepted.
- R8: If `u_len` is not 1 and `u_pdv` is low, the result is reason 8.
- R9: Reason 9 is given if `v_rd & u_wr` is non-zero (read after write) or `v_wr & u_rd` is non-zero (write after read).
- R10: Reason 9 is given on a flags read-after-write (`u_fwr` and `v_frd`) or a flags write-after-read (`v_fwr` and `u_frd`). The exception is class 3 in slot U with class 12 in slot V: that flags read-after-write is exempt.
- R11: When several rules fail, `reason` reports the lowest failing number. `pair_ok` is high exactly when `reason` is 0.
- R12: Outputs are registered, so they reflect the inputs one clock earlier. In reset, `pair_ok` is 0 and `reason` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| u_valid | input | 1 | Older descriptor valid |
| u_op | input | 4 | Older operation class |
| u_simple | input | 1 | Older is in the simple set |
| u_disp | input | 1 | Older has a displacement |
| u_imm | input | 1 | Older has an immediate |
| u_pfx | input | 1 | Older has a prefix byte |
| u_esc | input | 1 | Older uses the two-byte escape |
| u_len | input | 4 | Older length in bytes |
| u_pdv | input | 1 | Older predecode-valid |
| u_rd | input | 8 | Older register read mask |
| u_wr | input | 8 | Older register write mask |
| u_frd | input | 1 | Older reads flags |
| u_fwr | input | 1 | Older writes flags |
| v_valid | input | 1 | Younger descriptor valid |
| v_op | input | 4 | Younger operation class |
| v_simple | input | 1 | Younger is in the simple set |
| v_disp | input | 1 | Younger has a displacement |
| v_imm | input | 1 | Younger has an immediate |
| v_pfx | input | 1 | Younger has a prefix byte |
| v_esc | input | 1 | Younger uses the two-byte escape |
| v_len | input | 4 | Younger length in bytes |
| v_pdv | input | 1 | Younger predecode-valid |
| v_rd | input | 8 | Younger register read mask |
| v_wr | input | 8 | Younger register write mask |
| v_frd | input | 1 | Younger reads flags |
| v_fwr | input | 1 | Younger writes flags |
| pair_ok | output | 1 | Both may issue together |
| reason | output | 4 | Rejection code, 0 when paired |

## Verification
The first sweep covers all 256 combinations of class pairs with every other field clean. It separates the simple-set test from the three slot restrictions, and shows that their priority is correct when two of them fail together. The second sweep covers every combination of the displacement, immediate, prefix, escape, length and predecode bits over two slot-V classes. It tells the escape exception for branches apart from a plain prefix, and the length gate apart from the displacement/immediate rule. A pseudo-random hazard sweep draws register masks and flag bits over several class pairs. It distinguishes read-after-write from write-after-read and tests whether the compare/branch exemption is correctly limited to the flags.

// File: rtl/pair_pkg.sv
package pair_pkg;
  typedef enum logic [3:0] {
    OC_MOV     = 4'd0,
    OC_ALU     = 4'd1,
    OC_ADCSBB  = 4'd2,
    OC_CMPTEST = 4'd3,
    OC_INCDEC  = 4'd4,
    OC_STACK   = 4'd5,
    OC_LEA     = 4'd6,
    OC_NOP     = 4'd7,
    OC_SHIFT   = 4'd8,
    OC_ROTCIMM = 4'd9,
    OC_JMP     = 4'd10,
    OC_CALL    = 4'd11,
    OC_JCC     = 4'd12,
    OC_CPLX0   = 4'd13,
    OC_CPLX1   = 4'd14,
    OC_CPLX2   = 4'd15
  } opc_e;

  localparam int unsigned N_RULE = 9;
  localparam int unsigned CODE_W = $clog2(N_RULE + 1);

  function automatic logic is_branch(input logic [3:0] op);
    return (op == OC_JMP) || (op == OC_CALL) || (op == OC_JCC);
  endfunction

  function automatic logic in_simple_set(input logic [3:0] op);
    return (op != OC_ROTCIMM) && (op < OC_CPLX0);
  endfunction
endpackage

// File: rtl/pair_slot_rules.sv
module pair_slot_rules
  import pair_pkg::*;
#(
  parameter bit          SLOT_U = 1'b1,
  parameter int unsigned LEN_W  = 4
) (
  input  logic [3:0]       op,
  input  logic             simple,
  input  logic             disp,
  input  logic             imm,
  input  logic             pfx,
  input  logic             esc,
  input  logic [LEN_W-1:0] len,
  input  logic             pdv,
  output logic             not_simple,
  output logic             shift_bad,
  output logic             carry_bad,
  output logic             branch_bad,
  output logic             dispimm_bad,
  output logic             pfx_bad,
  output logic             len_bad
);
  always_comb begin
    not_simple  = !simple || !in_simple_set(op);
    dispimm_bad = disp && imm;
  end

  generate
    if (SLOT_U) begin : g_primary
      always_comb begin
        shift_bad  = 1'b0;
        carry_bad  = (op == OC_ADCSBB);
        branch_bad = is_branch(op);
        pfx_bad    = 1'b0;
        len_bad    = (len != LEN_W'(1)) && !pdv;
      end
    end else begin : g_secondary
      always_comb begin
        shift_bad  = (op == OC_SHIFT);
        carry_bad  = 1'b0;
        branch_bad = 1'b0;
        pfx_bad    = pfx || (esc && (op != OC_JCC));
        len_bad    = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/pair_hazard.sv
module pair_hazard
  import pair_pkg::*;
#(
  parameter int unsigned N_REG = 8
) (
  input  logic [3:0]       u_op,
  input  logic [3:0]       v_op,
  input  logic [N_REG-1:0] u_rd,
  input  logic [N_REG-1:0] u_wr,
  input  logic [N_REG-1:0] v_rd,
  input  logic [N_REG-1:0] v_wr,
  input  logic             u_frd,
  input  logic             u_fwr,
  input  logic             v_frd,
  input  logic             v_fwr,
  output logic             hazard
);
  logic reg_raw, reg_war, flg_raw, flg_war, flg_exempt;

  always_comb begin
    reg_raw    = |(v_rd & u_wr);
    reg_war    = |(v_wr & u_rd);
    flg_exempt = (u_op == OC_CMPTEST) && (v_op == OC_JCC);
    flg_raw    = u_fwr && v_frd && !flg_exempt;
    flg_war    = v_fwr && u_frd;
    hazard     = reg_raw || reg_war || flg_raw || flg_war;
  end
endmodule

// File: rtl/pair_prio.sv
module pair_prio #(
  parameter int unsigned N_IN   = 9,
  parameter int unsigned CODE_W = 4
) (
  input  logic [N_IN-1:0]   fail,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (fail[i]) code = CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/pair_check.sv
module pair_check
  import pair_pkg::*;
#(
  parameter int unsigned N_REG = 8,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             u_valid,
  input  logic [3:0]       u_op,
  input  logic             u_simple,
  input  logic             u_disp,
  input  logic             u_imm,
  input  logic             u_pfx,
  input  logic             u_esc,
  input  logic [LEN_W-1:0] u_len,
  input  logic             u_pdv,
  input  logic [N_REG-1:0] u_rd,
  input  logic [N_REG-1:0] u_wr,
  input  logic             u_frd,
  input  logic             u_fwr,
  input  logic             v_valid,
  input  logic [3:0]       v_op,
  input  logic             v_simple,
  input  logic             v_disp,
  input  logic             v_imm,
  input  logic             v_pfx,
  input  logic             v_esc,
  input  logic [LEN_W-1:0] v_len,
  input  logic             v_pdv,
  input  logic [N_REG-1:0] v_rd,
  input  logic [N_REG-1:0] v_wr,
  input  logic             v_frd,
  input  logic             v_fwr,
  output logic             pair_ok,
  output logic [CODE_W-1:0] reason
);
  logic u_ns, u_sh, u_cy, u_br, u_di, u_pf, u_ln;
  logic v_ns, v_sh, v_cy, v_br, v_di, v_pf, v_ln;
  logic hazard;
  logic [N_RULE-1:0]  fail;
  logic [CODE_W-1:0]  code_d;
  logic               ok_d;
  logic               ok_q;
  logic [CODE_W-1:0]  code_q;
  logic               load_en;

  pair_slot_rules #(.SLOT_U(1'b1), .LEN_W(LEN_W)) u_rules_u (
    .op(u_op), .simple(u_simple), .disp(u_disp), .imm(u_imm), .pfx(u_pfx),
    .esc(u_esc), .len(u_len), .pdv(u_pdv),
    .not_simple(u_ns), .shift_bad(u_sh), .carry_bad(u_cy), .branch_bad(u_br),
    .dispimm_bad(u_di), .pfx_bad(u_pf), .len_bad(u_ln)
  );

  pair_slot_rules #(.SLOT_U(1'b0), .LEN_W(LEN_W)) u_rules_v (
    .op(v_op), .simple(v_simple), .disp(v_disp), .imm(v_imm), .pfx(v_pfx),
    .esc(v_esc), .len(v_len), .pdv(v_pdv),
    .not_simple(v_ns), .shift_bad(v_sh), .carry_bad(v_cy), .branch_bad(v_br),
    .dispimm_bad(v_di), .pfx_bad(v_pf), .len_bad(v_ln)
  );

  pair_hazard #(.N_REG(N_REG)) u_hazard (
    .u_op(u_op), .v_op(v_op), .u_rd(u_rd), .u_wr(u_wr), .v_rd(v_rd), .v_wr(v_wr),
    .u_frd(u_frd), .u_fwr(u_fwr), .v_frd(v_frd), .v_fwr(v_fwr), .hazard(hazard)
  );

  // Rule vector, bit i maps to reason code i+1 (lowest index wins).
  always_comb begin
    fail[0] = !(u_valid && v_valid);
    fail[1] = u_ns || v_ns;
    fail[2] = u_sh || v_sh;
    fail[3] = u_cy || v_cy;
    fail[4] = u_br || v_br;
    fail[5] = u_di || v_di;
    fail[6] = u_pf || v_pf;
    fail[7] = u_ln || v_ln;
    fail[8] = hazard;
    ok_d    = ~|fail;
  end

  pair_prio #(.N_IN(N_RULE), .CODE_W(CODE_W)) u_prio (
    .fail(fail), .code(code_d)
  );

  assign load_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      code_q <= CODE_W'(1);
    end else if (load_en) begin
      ok_q   <= ok_d;
      code_q <= code_d;
    end
  end

  assign pair_ok = ok_q;
  assign reason  = code_q;

  // Assertion support: marks the first clock after reset release.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_invalid_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(u_valid && v_valid) |-> (!pair_ok && reason == CODE_W'(1)));

  p_ok_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ok == (reason == '0));

  p_dispimm_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    pair_ok |-> $past(!(u_disp && u_imm) && !(v_disp && v_imm)));

  p_len_gate_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    pair_ok |-> $past((u_len == LEN_W'(1)) || u_pdv));

  p_reg_dep_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    pair_ok |-> $past(((v_rd & u_wr) | (v_wr & u_rd)) == '0));

  p_vshift_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    pair_ok |-> $past(v_op != OC_SHIFT));

  p_vprefix_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    pair_ok |-> $past(!v_pfx && (!v_esc || v_op == OC_JCC)));
endmodule

// File: tb/pair_check_tb.sv
`timescale 1ns/1ps
module pair_check_tb;
  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic       u_valid, u_simple, u_disp, u_imm, u_pfx, u_esc, u_pdv, u_frd, u_fwr;
  logic       v_valid, v_simple, v_disp, v_imm, v_pfx, v_esc, v_pdv, v_frd, v_fwr;
  logic [3:0] u_op, v_op, u_len, v_len;
  logic [7:0] u_rd, u_wr, v_rd, v_wr;
  logic       pair_ok;
  logic [3:0] reason;

  int total = 0;
  int bad   = 0;

  pair_check u_dut (
    .clk(clk), .rst_n(rst_n),
    .u_valid(u_valid), .u_op(u_op), .u_simple(u_simple), .u_disp(u_disp),
    .u_imm(u_imm), .u_pfx(u_pfx), .u_esc(u_esc), .u_len(u_len), .u_pdv(u_pdv),
    .u_rd(u_rd), .u_wr(u_wr), .u_frd(u_frd), .u_fwr(u_fwr),
    .v_valid(v_valid), .v_op(v_op), .v_simple(v_simple), .v_disp(v_disp),
    .v_imm(v_imm), .v_pfx(v_pfx), .v_esc(v_esc), .v_len(v_len), .v_pdv(v_pdv),
    .v_rd(v_rd), .v_wr(v_wr), .v_frd(v_frd), .v_fwr(v_fwr),
    .pair_ok(pair_ok), .reason(reason)
  );

  // Reference model built from the requirement list.
  function automatic int exp_code();
    if (!(u_valid && v_valid)) return 1;                                   // R1
    if (!u_simple || !v_simple || u_op == 9 || v_op == 9 || u_op >= 13 || v_op >= 13)
      return 2;                                                            // R2
    if (v_op == 8) return 3;                                               // R3
    if (u_op == 2) return 4;                                               // R4
    if (u_op >= 10 && u_op <= 12) return 5;                                // R5
    if ((u_disp && u_imm) || (v_disp && v_imm)) return 6;                  // R6
    if (v_pfx || (v_esc && v_op != 12)) return 7;                          // R7
    if (u_len != 1 && !u_pdv) return 8;                                    // R8
    if ((v_rd & u_wr) != 0 || (v_wr & u_rd) != 0) return 9;               // R9
    if ((u_fwr && v_frd && !(u_op == 3 && v_op == 12)) || (v_fwr && u_frd))
      return 9;                                                            // R10
    return 0;                                                              // R11
  endfunction

  function automatic string tag(input int c);
    case (c)
      0: return "R11";
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9/R10";
    endcase
  endfunction

  task automatic clean();
    u_valid = 1; v_valid = 1; u_simple = 1; v_simple = 1;
    u_disp = 0; u_imm = 0; u_pfx = 0; u_esc = 0; u_len = 1; u_pdv = 0;
    v_disp = 0; v_imm = 0; v_pfx = 0; v_esc = 0; v_len = 2; v_pdv = 0;
    u_rd = 0; u_wr = 0; v_rd = 0; v_wr = 0;
    u_frd = 0; u_fwr = 0; v_frd = 0; v_fwr = 0;
    u_op = 0; v_op = 0;
  endtask

  // Inputs are set at a falling edge; R12: result visible after the next rising edge.
  task automatic run_vec();
    int e;
    e = exp_code();
    @(posedge clk);
    #2;
    total++;
    if (int'(reason) != e || pair_ok != (e == 0)) begin
      bad++;
      $display("FAIL %s: u_op=%0d v_op=%0d reason=%0d pair_ok=%0b expected reason=%0d pair_ok=%0b",
               tag(e), u_op, v_op, reason, pair_ok, e, (e == 0));
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    clean();
    u_valid = 1; v_valid = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    total++;
    if (pair_ok !== 1'b0 || reason !== 4'd1) begin
      bad++;
      $display("FAIL R12: reset pair_ok=%0b reason=%0d expected pair_ok=0 reason=1", pair_ok, reason);
    end
    rst_n = 1;
    @(negedge clk);

    // R1 valid gating
    for (int k = 0; k < 4; k++) begin
      clean(); u_valid = k[0]; v_valid = k[1]; v_op = 8;
      run_vec();
    end

    // R2..R5, R11: every class pair
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        clean(); u_op = 4'(a); v_op = 4'(b);
        run_vec();
      end
    end

    // R2 simple flags
    for (int k = 0; k < 4; k++) begin
      clean(); u_simple = k[0]; v_simple = k[1]; u_op = 1; v_op = 12;
      run_vec();
    end

    // R6, R7, R8 and priority among them (R11)
    for (int m = 0; m < 1024; m++) begin
      clean();
      u_disp = m[0]; u_imm = m[1]; v_disp = m[2]; v_imm = m[3];
      u_pfx = m[4]; v_pfx = m[5]; v_esc = m[6]; u_pdv = m[7];
      u_len = m[8] ? 4'd3 : 4'd1;
      v_op = m[9] ? 4'd12 : 4'd1;
      u_op = 4'd0;
      run_vec();
    end

    // R9, R10 hazards
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 800; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      clean();
      u_rd = lf[7:0] & lf[15:8];
      u_wr = lf[15:8] & lf[23:16];
      v_rd = lf[23:16] & lf[31:24];
      v_wr = lf[31:24] & lf[7:0] & lf[11:4];
      u_frd = lf[3]; u_fwr = lf[9]; v_frd = lf[17]; v_fwr = lf[26];
      case (lf[29:28])
        2'd0: u_op = 1; 2'd1: u_op = 3; 2'd2: u_op = 0; default: u_op = 4;
      endcase
      case (lf[31:30])
        2'd0: v_op = 12; 2'd1: v_op = 1; 2'd2: v_op = 0; default: v_op = 7;
      endcase
      if (n % 4 == 0) begin u_rd = 0; u_wr = 0; v_rd = 0; v_wr = 0; end
      run_vec();
    end

    // R10 exemption corner: compare/test then conditional branch
    clean(); u_op = 3; v_op = 12; u_fwr = 1; v_frd = 1;
    run_vec();
    clean(); u_op = 1; v_op = 12; u_fwr = 1; v_frd = 1;
    run_vec();
    clean(); u_op = 3; v_op = 12; u_frd = 1; v_fwr = 1;
    run_vec();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule